// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is a configurable AND plane feeding a fixed OR plane. Twenty-two array inputs are each expanded into a true line and a complement line. Each product-term row holds one configuration bit per line, and a set bit connects that line to the row's AND. The rows are then grouped: each of ten outputs owns one enable row and a run of sum rows that are ORed together. Two further rows are exported on their own for an asynchronous-reset use and a synchronous-preset use. Registers and output cells live outside this block.

The whole configuration arrives as one flat vector. Row `t`, line `l` sits at bit `t*44 + l`. Every output is a pure combinational function of the inputs and the configuration, so there is no clock, no reset and no handshake. Valid/ready flow control has no place in a block with no state and no data transfer.

Top module: `sop_array`

## Requirements
- R1: Line `2*i` carries input `i` in true form, and line `2*i+1` carries it inverted, for `i` from 0 to 21.
- R2: Configuration bit `t*44 + l` (with `cfg_bits` bit 0 as the LSB) connects line `l` to product row `t` when it is set to 1. There are 132 rows, which gives 5808 bits.
- R3: A row is true exactly when every line connected to it is high. A row with no connected lines is true.
- R4: A row that has both lines of any one input connected is false for every input value.
- R5: Row 0 drives `ar_term`, and row 131 drives `sp_term`.
- R6: Rows 1..130 are split among outputs 0..9 in ascending order. Output k's run starts with its enable row and continues with its sum rows. The sum-row counts, from output 0 to output 9, are 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8.
- R7: `sum_out[k]` is the OR of output k's sum rows only. Its enable row has no part in it.
- R8: `oe_out[k]` equals output k's enable row.
- R9: An input that no row connects to has no effect on any output.
- R10: All outputs settle in the same cycle as the input or configuration change that causes them, with no register on any path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_vec | input | 22 | Array inputs |
| cfg_bits | input | 5808 | Flat connection map, row-major with 44 bits per row |
| sum_out | output | 10 | OR of each output's sum rows |
| oe_out | output | 10 | Enable row of each output |
| ar_term | output | 1 | Global row 0 |
| sp_term | output | 1 | Global row 131 |

## Verification
Every result is due zero cycles after its stimulus, because no path through the block holds a register. The bench changes inputs and configuration just after a rising edge and samples half a period later, at the falling edge. Every output has settled by then, and the next change has not yet been applied. The same timing holds for table-driven vectors and for directed cases alike, so no check relies on a latency count.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Sum rows owned by output k: ramps up by step to the middle, then back down.
  function automatic int sum_rows(input int k, input int n_out,
                                  input int min_rows, input int step);
    if (k < n_out / 2) return min_rows + step * k;
    return min_rows + step * (n_out - 1 - k);
  endfunction

  // Index of output k's enable row. Row 0 is the global reset row.
  function automatic int group_base(input int k, input int n_out,
                                    input int min_rows, input int step);
    int b;
    b = 1;
    for (int j = 0; j < k; j++) b += 1 + sum_rows(j, n_out, min_rows, step);
    return b;
  endfunction

endpackage

// File: rtl/sop_literals.sv
module sop_literals #(
  parameter int IN_W = 22,
  localparam int LINES = 2 * IN_W
) (
  input  logic [IN_W-1:0]  in_vec,
  output logic [LINES-1:0] lines
);
  for (genvar i = 0; i < IN_W; i++) begin : g_pair
    assign lines[2*i]   = in_vec[i];
    assign lines[2*i+1] = ~in_vec[i];
  end
endmodule

// File: rtl/sop_pterm.sv
module sop_pterm #(
  parameter int LINES = 44,
  localparam int PAIRS = LINES / 2
) (
  input  logic [LINES-1:0] lines,
  input  logic [LINES-1:0] mask,
  output logic             term
);
  logic erased;

  always_comb begin
    term = &(lines | ~mask);
    erased = 1'b0;
    for (int p = 0; p < PAIRS; p++) erased = erased | (mask[2*p] & mask[2*p+1]);
    AST_ERASED_FALSE: assert (!erased || !term) else $error("erased row true"); // R4
    AST_EMPTY_TRUE: assert (mask != '0 || term) else $error("empty row false"); // R3
  end
endmodule

// File: rtl/sop_or_group.sv
module sop_or_group #(
  parameter int N = 8
) (
  input  logic [N-1:0] terms,
  output logic         any
);
  always_comb begin
    any = |terms;
    AST_GROUP_ZERO: assert (any || terms == '0) else $error("group low with live row"); // R7
    AST_GROUP_ONE: assert (!any || $countones(terms) > 0) else $error("group high with no row"); // R7
  end
endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int IN_W     = 22,
  parameter int OUT_N    = 10,
  parameter int MIN_SUM  = 8,
  parameter int SUM_STEP = 2,
  localparam int LINES = 2 * IN_W,
  localparam int TERMS = sop_pkg::group_base(OUT_N, OUT_N, MIN_SUM, SUM_STEP) + 1,
  localparam int CFG_W = TERMS * LINES
) (
  input  logic [IN_W-1:0]  in_vec,
  input  logic [CFG_W-1:0] cfg_bits,
  output logic [OUT_N-1:0] sum_out,
  output logic [OUT_N-1:0] oe_out,
  output logic             ar_term,
  output logic             sp_term
);
  logic [LINES-1:0] lines;
  logic [TERMS-1:0] pt;

  sop_literals #(.IN_W(IN_W)) u_lit (
    .in_vec (in_vec),
    .lines  (lines)
  );

  for (genvar t = 0; t < TERMS; t++) begin : g_row
    sop_pterm #(.LINES(LINES)) u_pt (
      .lines (lines),
      .mask  (cfg_bits[t*LINES +: LINES]),
      .term  (pt[t])
    );
  end

  for (genvar k = 0; k < OUT_N; k++) begin : g_out
    localparam int BASE = sop_pkg::group_base(k, OUT_N, MIN_SUM, SUM_STEP);
    localparam int NS   = sop_pkg::sum_rows(k, OUT_N, MIN_SUM, SUM_STEP);

    assign oe_out[k] = pt[BASE];

    sop_or_group #(.N(NS)) u_or (
      .terms (pt[BASE+1 +: NS]),
      .any   (sum_out[k])
    );

    always_comb begin
      if (pt[BASE+1 +: NS] == '0)
        AST_ENABLE_APART: assert (sum_out[k] == 1'b0) else $error("enable row leaked into sum"); // R7
    end
  end

  assign ar_term = pt[0];
  assign sp_term = pt[TERMS-1];
endmodule

// File: tb/sim_sop_array.sv
`timescale 1ns/1ps
module sim_sop_array;
  localparam int IN_W = 22;
  localparam int OUT_N = 10;
  localparam int LINES = 44;
  localparam int TERMS = 132;
  localparam int CFG_W = TERMS * LINES;
  localparam int SUMS [OUT_N] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  // Row layout: [44] config select (0 = C, 1 = D), [43:22] in, [21:12] sum, [11:2] oe, [1] ar, [0] sp
  localparam int NV = 8;
  localparam logic [44:0] TBL [NV] = '{
    {1'b0, 22'h000000, 10'h000, 10'h3FF, 1'b0, 1'b1},
    {1'b0, 22'h3FFFFF, 10'h3FF, 10'h000, 1'b1, 1'b0},
    {1'b0, 22'h155555, 10'h155, 10'h2AA, 1'b0, 1'b1},
    {1'b0, 22'h2AAAAA, 10'h2AA, 10'h155, 1'b0, 1'b0},
    {1'b0, 22'h300001, 10'h001, 10'h3FF, 1'b1, 1'b0},
    {1'b0, 22'h0FFC00, 10'h000, 10'h000, 1'b0, 1'b1},
    {1'b1, 22'h000201, 10'h201, 10'h000, 1'b0, 1'b0},
    {1'b1, 22'h3FFDFE, 10'h1FE, 10'h000, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [IN_W-1:0]  in_vec;
  logic [CFG_W-1:0] cfg;
  logic [OUT_N-1:0] sum_out, oe_out;
  logic ar_term, sp_term;
  int nchk = 0, nerr = 0;
  bit done = 0;

  sop_array u0 (
    .in_vec   (in_vec),
    .cfg_bits (cfg),
    .sum_out  (sum_out),
    .oe_out   (oe_out),
    .ar_term  (ar_term),
    .sp_term  (sp_term)
  );

  function automatic int base_of(input int k);
    int b = 1;
    for (int j = 0; j < k; j++) b += 1 + SUMS[j];
    return b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [IN_W-1:0] v);
    @(posedge clk);
    #1 in_vec = v;
    @(negedge clk);
  endtask

  task automatic kill_all();
    cfg = '0;
    for (int t = 0; t < TERMS; t++) begin
      cfg[t*LINES + 0] = 1'b1;
      cfg[t*LINES + 1] = 1'b1;
    end
  endtask

  task automatic only_line(input int t, input int l);
    cfg[t*LINES +: LINES] = '0;
    cfg[t*LINES + l] = 1'b1;
  endtask

  task automatic build_c();
    kill_all();
    for (int k = 0; k < OUT_N; k++) begin
      only_line(base_of(k) + 1, 2*k);
      only_line(base_of(k), 2*(k+10) + 1);
    end
    cfg[0 +: LINES] = '0;
    cfg[2*20] = 1'b1;
    cfg[2*21] = 1'b1;
    only_line(TERMS-1, 2*21 + 1);
  endtask

  task automatic build_d();
    kill_all();
    for (int k = 0; k < OUT_N; k++) only_line(base_of(k) + SUMS[k], 2*k);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    in_vec = '0;
    cfg = '0;
    // R3: empty rows are all true
    apply(22'h2F0F0F);
    chk("R3 empty sum", 32'(sum_out), 32'h3FF);
    chk("R3 empty oe", 32'(oe_out), 32'h3FF);
    chk("R3 empty globals", {30'd0, ar_term, sp_term}, 32'h3);
    // R4: fully erased rows are all false
    cfg = '1;
    apply(22'h3FFFFF);
    chk("R4 erased all", {10'd0, sum_out, oe_out, ar_term, sp_term}, 32'h0);
    apply(22'h000000);
    chk("R4 erased zeros", {10'd0, sum_out, oe_out, ar_term, sp_term}, 32'h0);

    // Table: R1 R5 R6 R7 R8 across two configurations
    for (int v = 0; v < NV; v++) begin
      if (TBL[v][44]) build_d(); else build_c();
      apply(TBL[v][43:22]);
      chk("R6 R7 sum", 32'(sum_out), 32'(TBL[v][21:12]));
      chk("R8 R1 oe", 32'(oe_out), 32'(TBL[v][11:2]));
      chk("R5 globals", {30'd0, ar_term, sp_term}, {30'd0, TBL[v][1:0]});
    end

    // R9: unconnected input 15 under config D changes nothing
    build_d();
    apply(22'h000155);
    chk("R9 before", {10'd0, sum_out, oe_out, ar_term, sp_term}, {10'd0, 10'h155, 10'h000, 2'b00});
    apply(22'h008155);
    chk("R9 after toggle", {10'd0, sum_out, oe_out, ar_term, sp_term}, {10'd0, 10'h155, 10'h000, 2'b00});

    // R2: a single cell in the last row (true line of input 5)
    cfg = '0;
    cfg[131*LINES + 10] = 1'b1;
    apply(22'h000000);
    chk("R2 sp low", 32'(sp_term), 32'h0);
    chk("R2 others unaffected", 32'(sum_out), 32'h3FF);
    apply(22'h000020);
    chk("R2 sp high", 32'(sp_term), 32'h1);
    // R2 R1: complement line of input 7 on row 0
    cfg = '0;
    cfg[0*LINES + 15] = 1'b1;
    apply(22'h000080);
    chk("R1 ar complement low", 32'(ar_term), 32'h0);
    // R10: a configuration change alone shows within the same cycle
    @(posedge clk);
    #1 cfg[0*LINES + 15] = 1'b0;
    @(negedge clk);
    chk("R10 same cycle", 32'(ar_term), 32'h1);

    finish_run();
  end
endmodule